// File: doc/BRIEF.md
# Word-Wide One-Time-Programmable Memory Emulator

This block is a clocked, synthesizable stand-in for a word-wide one-time-programmable memory, 16 bits per word. Its state at reset is an array of all ones. The only change a program operation can make is to clear bits: the applied word is ANDed into the stored word. A program step is one falling edge of the active-low chip enable, with the programming flag set and output enable high. The block decodes six modes from the two active-low enables and two high-voltage flags. Four of them are read, program, program-inhibit and program-verify. Identify returns one of two fixed codes, chosen by address bit 0. Idle covers every other combination.

Read data leaves on a valid/data pair, with no ready input. The output has no back-pressure. The word and its valid flag hold for as long as the request stays unchanged, and a consumer may sample them on any cycle in which valid is high. A request is the mode plus the address. Changing it, or dropping it, lowers valid in the same cycle. Valid rises again a parameterised number of clock edges later, which models access time.

Top module: `otp_word_mem`

## Requirements
- R1: After reset, every word reads as 16'hFFFF.
- R2: A program operation stores (old AND din). No bit is ever set from 0 to 1.
- R3: A write takes place only at the first clock edge that samples ce_n low after ce_n was high, with vpp_on set, id_on clear and oe_n high. Holding ce_n low writes only once. A ce_n pulse with vpp_on clear writes nothing.
- R4: With vpp_on set and ce_n high, no write takes place, whatever din, addr and oe_n carry.
- R5: With vpp_on set, ce_n high and oe_n low (verify), dout presents the stored word at addr.
- R6: A normal read (dout_valid high with the stored word) needs ce_n and oe_n both low with vpp_on and id_on clear. With vpp_on set and both enables low, nothing is output.
- R7: With id_on set and both enables low, addr[0]=0 returns the manufacturer code {p, MFR_ID} and addr[0]=1 returns the device code {p, DEV_ID}.
- R8: Both identifier words have odd parity over all 16 bits, with bit 15 as the parity bit p.
- R9: dout_valid rises at the ACC_LAT-th clock edge after the request (mode and addr) was applied or changed. It falls in the same cycle the request changes or ends.
- R10: While id_on is set, no write takes place.
- R11: dout is 16'h0000 whenever dout_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; sets the whole array to ones |
| addr | input | ADDR_W | Word address (bit 0 also picks the identifier) |
| din | input | 16 | Word to program (zeros clear bits) |
| ce_n | input | 1 | Active-low chip enable; its falling edge is the program pulse |
| oe_n | input | 1 | Active-low output enable |
| vpp_on | input | 1 | Programming voltage present |
| id_on | input | 1 | Identify voltage present on address bit 9 |
| dout | output | 16 | Output word, zero when not valid |
| dout_valid | output | 1 | Output word valid |

## Verification
The tests separate the program paths by what each one leaves in the array. A clean falling pulse clears only the zero bits of din. A second pulse with overlapping data shows that ones never come back. Holding ce_n low while din changes shows that only one write took place. Pulses with ce_n held high, with vpp_on clear and with id_on set show that nothing was written. Both identifier words are compared against codes whose parity the bench computes itself. Address changes in the middle of an access confirm that valid drops at once and returns after exactly ACC_LAT edges.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [2:0] {
    M_IDLE    = 3'd0,
    M_READ    = 3'd1,
    M_PROG    = 3'd2,
    M_INHIBIT = 3'd3,
    M_VERIFY  = 3'd4,
    M_IDENT   = 3'd5
  } otp_mode_e;

  localparam int unsigned WORD_W = 16;

  // Parity bit that makes a 16-bit word carry an odd number of ones.
  function automatic logic odd_par_bit(input logic [WORD_W-2:0] payload);
    return ~(^payload);
  endfunction
endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_pkg::*;
(
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      vpp_on,
  input  logic      id_on,
  output otp_mode_e mode,
  output logic      out_mode
);
  always_comb begin
    mode = M_IDLE;
    if (id_on) begin
      if (!ce_n && !oe_n) mode = M_IDENT;
    end else if (vpp_on) begin
      unique case ({ce_n, oe_n})
        2'b01:   mode = M_PROG;
        2'b10:   mode = M_VERIFY;
        2'b11:   mode = M_INHIBIT;
        default: mode = M_IDLE;
      endcase
    end else if (!ce_n && !oe_n) begin
      mode = M_READ;
    end
  end

  assign out_mode = (mode == M_READ) || (mode == M_VERIFY) || (mode == M_IDENT);
endmodule

// File: rtl/otp_array.sv
module otp_array
  import otp_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (wr_en) begin
      mem[addr] <= mem[addr] & wr_data;
    end
  end

  assign rd_data = mem[addr];
endmodule

// File: rtl/otp_id_rom.sv
module otp_id_rom
  import otp_pkg::*;
#(
  parameter logic [WORD_W-2:0] MFR_ID = 15'h00C2,
  parameter logic [WORD_W-2:0] DEV_ID = 15'h0042
) (
  input  logic              sel_dev,
  output logic [WORD_W-1:0] id_word
);
  localparam logic [WORD_W-1:0] MFR_WORD = {odd_par_bit(MFR_ID), MFR_ID};
  localparam logic [WORD_W-1:0] DEV_WORD = {odd_par_bit(DEV_ID), DEV_ID};

  assign id_word = sel_dev ? DEV_WORD : MFR_WORD;
endmodule

// File: rtl/otp_access_timer.sv
module otp_access_timer #(
  parameter int unsigned ACC_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic changed,
  output logic ready_out
);
  localparam int unsigned CW = $clog2(ACC_LAT + 1);
  localparam logic [CW-1:0] LAT_V = CW'(ACC_LAT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!active)       cnt <= '0;
    else if (changed)       cnt <= CW'(1);
    else if (cnt < LAT_V)   cnt <= cnt + CW'(1);
  end

  assign ready_out = active && !changed && (cnt == LAT_V);
endmodule

// File: rtl/otp_word_mem.sv
module otp_word_mem
  import otp_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 8,
  parameter int unsigned       ACC_LAT = 2,
  parameter logic [14:0]       MFR_ID  = 15'h00C2,
  parameter logic [14:0]       DEV_ID  = 15'h0042
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       din,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_on,
  input  logic              id_on,
  output logic [15:0]       dout,
  output logic              dout_valid
);
  localparam int unsigned KEY_W = ADDR_W + 3;

  otp_mode_e         mode;
  logic              out_mode;
  logic              ce_n_q;
  logic              wr_en;
  logic [WORD_W-1:0] rd_data;
  logic [WORD_W-1:0] id_word;
  logic [WORD_W-1:0] out_q;
  logic [KEY_W-1:0]  key, key_q;
  logic              changed;
  logic              timer_ok;

  otp_mode_decode u_dec (
    .ce_n(ce_n), .oe_n(oe_n), .vpp_on(vpp_on), .id_on(id_on),
    .mode(mode), .out_mode(out_mode)
  );

  // Program pulse: first edge with ce_n low after ce_n was high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ce_n_q <= 1'b1;
    else        ce_n_q <= ce_n;
  end
  assign wr_en = (mode == M_PROG) && ce_n_q;

  otp_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(din), .rd_data(rd_data)
  );

  otp_id_rom #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_id (
    .sel_dev(addr[0]), .id_word(id_word)
  );

  assign key     = {mode, addr};
  assign changed = (key != key_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      out_q <= '0;
    end else begin
      key_q <= key;
      out_q <= (mode == M_IDENT) ? id_word : rd_data;
    end
  end

  otp_access_timer #(.ACC_LAT(ACC_LAT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .active(out_mode), .changed(changed),
    .ready_out(timer_ok)
  );

  assign dout_valid = timer_ok;
  assign dout       = timer_ok ? out_q : '0;
endmodule

// File: rtl/otp_word_mem_chk.sv
module otp_word_mem_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ce_n,
  input logic              oe_n,
  input logic              vpp_on,
  input logic              id_on,
  input logic              wr_en,
  input logic [15:0]       dout,
  input logic              dout_valid
);
  // R3: a write follows a sampled high chip enable
  a_r3_write_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(ce_n) && !ce_n && oe_n && vpp_on));

  // R4: high chip enable with programming voltage never writes
  a_r4_inhibit_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_on && ce_n) |-> !wr_en);

  // R10: identify voltage blocks writes
  a_r10_id_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    id_on |-> !wr_en);

  // R6: output needs output enable
  a_r6_valid_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> !oe_n);

  // R9: valid data implies the address was stable since the last edge
  a_r9_valid_stable_addr: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> $stable(addr));

  // R8: identifier output has odd parity
  a_r8_id_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && id_on) |-> ($countones(dout) % 2 == 1));

  // R11: no data when not valid
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_valid |-> (dout == 16'h0000));
endmodule

bind otp_word_mem otp_word_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
  .vpp_on(vpp_on), .id_on(id_on), .wr_en(wr_en), .dout(dout),
  .dout_valid(dout_valid)
);

// File: tb/otp_word_mem_test.sv
module otp_word_mem_test;
  localparam int unsigned AW  = 8;
  localparam int unsigned LAT = 3;
  localparam logic [14:0] MFR = 15'h00C2;
  localparam logic [14:0] DEV = 15'h0043;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   din = '1;
  logic          ce_n = 1'b1, oe_n = 1'b1, vpp_on = 1'b0, id_on = 1'b0;
  logic [15:0]   dout;
  logic          dout_valid;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  otp_word_mem #(.ADDR_W(AW), .ACC_LAT(LAT), .MFR_ID(MFR), .DEV_ID(DEV)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n),
    .oe_n(oe_n), .vpp_on(vpp_on), .id_on(id_on), .dout(dout),
    .dout_valid(dout_valid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] id_exp(input logic [14:0] p);
    int ones = 0;
    for (int i = 0; i < 15; i++) ones += int'(p[i]);
    return {(ones % 2 == 0), p};
  endfunction

  task automatic go_idle();
    @(negedge clk);
    ce_n = 1; oe_n = 1; vpp_on = 0; id_on = 0;
    @(negedge clk);
  endtask

  // Apply an output request and check latency, data and the R11 zero.
  task automatic access(input string tag, input logic [AW-1:0] a,
                        input logic v, input logic idf, input logic c,
                        input logic [15:0] exp);
    @(negedge clk);
    addr = a; vpp_on = v; id_on = idf; ce_n = c; oe_n = 0;
    for (int k = 1; k < LAT; k++) @(negedge clk);
    chk({tag, " R9 early valid"}, dout_valid, 0);
    chk({tag, " R11 zero early"}, dout, 16'h0);
    @(negedge clk);
    chk({tag, " R9 valid"}, dout_valid, 1);
    chk(tag, dout, exp);
    go_idle();
  endtask

  task automatic pulse(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; din = d; vpp_on = 1; oe_n = 1; ce_n = 1;
    @(negedge clk) ce_n = 0;
    @(negedge clk) ce_n = 1;
    go_idle();
  endtask

  task automatic t_reset();
    chk("R11 reset valid", dout_valid, 0);
    access("R1 erased 0", 8'h00, 0, 0, 0, 16'hFFFF);
    access("R1 erased FF", 8'hFF, 0, 0, 0, 16'hFFFF);
  endtask

  task automatic t_program();
    pulse(8'h10, 16'hA5F0);
    access("R2 first program", 8'h10, 0, 0, 0, 16'hA5F0);
    pulse(8'h10, 16'h5FFF);
    access("R2 only clears", 8'h10, 0, 0, 0, 16'h05F0);
    access("R2 neighbour intact", 8'h11, 0, 0, 0, 16'hFFFF);
  endtask

  task automatic t_hold();
    @(negedge clk);
    addr = 8'h20; din = 16'hFF00; vpp_on = 1; oe_n = 1; ce_n = 1;
    @(negedge clk) ce_n = 0;
    @(negedge clk) din = 16'h00FF;
    @(negedge clk) din = 16'h0000;
    @(negedge clk) ce_n = 1;
    go_idle();
    access("R3 single write on hold", 8'h20, 0, 0, 0, 16'hFF00);
    // ce pulse without programming voltage
    @(negedge clk);
    addr = 8'h21; din = 16'h0000; vpp_on = 0; oe_n = 1; ce_n = 1;
    @(negedge clk) ce_n = 0;
    @(negedge clk) ce_n = 1;
    go_idle();
    access("R3 no write without vpp", 8'h21, 0, 0, 0, 16'hFFFF);
  endtask

  task automatic t_inhibit();
    @(negedge clk);
    addr = 8'h30; din = 16'h0000; vpp_on = 1; ce_n = 1; oe_n = 1;
    repeat (3) @(negedge clk);
    oe_n = 0;
    @(negedge clk) oe_n = 1;
    go_idle();
    access("R4 inhibit kept word", 8'h30, 0, 0, 0, 16'hFFFF);
    // identify voltage blocks a program pulse
    @(negedge clk);
    addr = 8'h31; din = 16'h0000; id_on = 1; vpp_on = 1; oe_n = 1; ce_n = 1;
    @(negedge clk) ce_n = 0;
    @(negedge clk) ce_n = 1;
    go_idle();
    access("R10 no write under id", 8'h31, 0, 0, 0, 16'hFFFF);
  endtask

  task automatic t_verify();
    pulse(8'h40, 16'h1234);
    access("R5 verify", 8'h40, 1, 0, 1, 16'h1234);
    @(negedge clk);
    addr = 8'h40; vpp_on = 1; ce_n = 0; oe_n = 0;
    repeat (LAT + 1) @(negedge clk);
    chk("R6 no output vpp both low", dout_valid, 0);
    chk("R11 zero vpp both low", dout, 16'h0);
    go_idle();
  endtask

  task automatic t_ident();
    access("R7 R8 manufacturer", 8'h00, 0, 1, 0, id_exp(MFR));
    access("R7 R8 device", 8'h01, 0, 1, 0, id_exp(DEV));
  endtask

  task automatic t_latency();
    @(negedge clk);
    addr = 8'h10; ce_n = 0; oe_n = 0;
    repeat (LAT + 2) @(negedge clk);
    chk("R9 steady valid", dout_valid, 1);
    addr = 8'h11;
    #1 chk("R9 drop on change", dout_valid, 0);
    for (int k = 1; k < LAT; k++) @(negedge clk);
    chk("R9 relatch early", dout_valid, 0);
    @(negedge clk);
    chk("R9 relatch valid", dout_valid, 1);
    chk("R9 relatch data", dout, 16'hFFFF);
    oe_n = 1;
    #1 chk("R6 drop on oe", dout_valid, 0);
    go_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_program();
    t_hold();
    t_inhibit();
    t_verify();
    t_ident();
    t_latency();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule